// File: doc/BRIEF.md
# Two-Wire Converter Result Reader

This block is the host side of a two-wire link to a delta-sigma converter. The link has a serial clock that the host drives and one line that the converter drives. That line first signals that a result is ready by going low, and it then carries the result bits. The reader takes one-shot commands on a small command port and runs each one to completion:

- **Reads.** For a read it waits for the line to fall and generates the serial clock. It captures the 24-bit two's complement word, most significant bit first, and returns it both as is and sign-extended to 32 bits. Depending on the command it adds one extra pulse, which returns the line to its high idle level. It can instead add two extra pulses, which also start a self-calibration. In that case it waits for the line to fall again.
- **Sleep and wake.** The reader can put the converter to sleep by parking the clock high once a result is ready. A wake command drops the clock and waits for the next result to be signalled.

The clock half-period comes from a divider setting in system cycles. A floor on that setting keeps each phase at the converter's 80 ns minimum. The waits for the line are guarded by a programmable cycle limit. Passing that limit reports an error and returns the block to idle.

Top module: `adc2w_host_reader`

## Requirements
- R1: After reset the serial clock is low, busy is low, and result_valid, done and timeout_err are low. The held result is zero.
- R2: Command codes on cmd_op are 0 = read (24 pulses), 1 = read and release (25 pulses), 2 = read and calibrate (26 pulses), 3 = sleep and 4 = wake. A command is taken only in the cycle cmd_valid is high while busy is low. Busy is high from the cycle after a command is taken until the block is idle again. Commands presented while busy, and codes 5 to 7, have no effect.
- R3: For commands 0 to 3, no rising edge of the serial clock is produced while the data line stays high.
- R4: The number of rising edges produced for commands 0, 1 and 2 is 24, 25 and 26 respectively. Bit k of the line, counted from 1, is sampled in the last cycle of the k-th high phase for k = 1..24, and it fills result bit 24-k. At the end of the last low phase, result_valid pulses for one cycle, result holds the word and result_sext holds it sign-extended to 32 bits.
- R5: Every high phase and every low phase inside a transfer lasts max(cfg_half, MIN_HALF) system cycles.
- R6: For command 2, busy stays high after result_valid until the data line is seen to go from high to low. done then pulses once.
- R7: For command 3, once the line is low the serial clock goes high and stays high with busy low. While it is held, every command except wake has no effect.
- R8: A wake command while asleep drives the serial clock low. done pulses on the next high-to-low transition of the data line. A wake command while not asleep has no effect.
- R9: If the awaited line level or transition does not arrive within cfg_timeout cycles of the wait starting, timeout_err pulses once and the block returns to idle without producing clock pulses.
- R10: done and timeout_err never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R2) |
| busy | output | 1 | High while a command is in progress |
| cfg_half | input | DIV_W | Requested half-period of the serial clock in system cycles |
| cfg_timeout | input | TO_W | Wait limit in system cycles |
| sclk | output | 1 | Serial clock to the converter |
| rdy_dout | input | 1 | Ready / data line from the converter |
| result | output | 24 | Last captured conversion word |
| result_sext | output | 32 | result sign-extended |
| result_valid | output | 1 | One-cycle strobe when result is updated |
| done | output | 1 | One-cycle strobe when a command completes normally |
| timeout_err | output | 1 | One-cycle strobe when a wait exceeds cfg_timeout |

## Verification
The bench builds the reader with MIN_HALF = 4, DIV_W = 8 and TO_W = 12. A four-cycle floor lets a requested half-period of 2 show the clamp, while settings of 5 to 8 exercise the divider above the floor. Twelve timeout bits keep a short limit of 30 cycles and a generous limit of 1000 within one bench. The short pulse phases keep 26-pulse calibration reads and long sleep holds well inside the run length.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;

  localparam int unsigned WORD_W = 24;
  localparam int unsigned SEXT_W = 32;

  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_READ_REL = 3'd1,
    OP_READ_CAL = 3'd2,
    OP_SLEEP    = 3'd3,
    OP_WAKE     = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_SHIFT,
    ST_WAIT_FALL
  } st_e;

  // clock pulses generated by each command
  function automatic int unsigned pulse_count(op_e op);
    case (op)
      OP_READ:     return 24;
      OP_READ_REL: return 25;
      OP_READ_CAL: return 26;
      default:     return 0;
    endcase
  endfunction

  // requested half-period raised to the floor
  function automatic int unsigned clamp_half(int unsigned req, int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  function automatic logic [SEXT_W-1:0] sign_extend(logic [WORD_W-1:0] w);
    return {{(SEXT_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction

endpackage

// File: rtl/adc2w_phase_timer.sv
module adc2w_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] half,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= half - W'(1);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/adc2w_capture.sv
module adc2w_capture #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (clear)    word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/adc2w_wait_timer.sv
module adc2w_wait_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clear)        cnt <= '0;
    else if (cnt != limit) cnt <= cnt + W'(1);
  end

  assign expired = (cnt == limit);
endmodule

// File: rtl/adc2w_host_reader.sv
module adc2w_host_reader
  import adc2w_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned TO_W     = 16,
  parameter int unsigned MIN_HALF = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  output logic                busy,
  input  logic [DIV_W-1:0]    cfg_half,
  input  logic [TO_W-1:0]     cfg_timeout,
  output logic                sclk,
  input  logic                rdy_dout,
  output logic [WORD_W-1:0]   result,
  output logic [SEXT_W-1:0]   result_sext,
  output logic                result_valid,
  output logic                done,
  output logic                timeout_err
);
  localparam int unsigned PIDX_W = 5;
  localparam logic [PIDX_W-1:0] DATA_PULSES = PIDX_W'(WORD_W);

  st_e               state;
  op_e               op_q;
  logic              sclk_q, asleep, rdy_q;
  logic [PIDX_W-1:0] pidx;
  logic [WORD_W-1:0] result_q, cap_word;
  logic [DIV_W-1:0]  half_eff;
  logic [PIDX_W-1:0] npulse;
  op_e               op_in;
  logic              op_legal;

  // named internal events
  logic ev_accept, ev_rdy_seen, ev_start, ev_sleep, ev_phase_end;
  logic ev_sample, ev_last, ev_fall, ev_expired;
  logic tick, wd_expired, timer_load, wd_clear;

  assign half_eff = DIV_W'(clamp_half(32'(cfg_half), MIN_HALF));
  assign npulse   = PIDX_W'(pulse_count(op_q));
  assign op_in    = op_e'(cmd_op);
  assign op_legal = (cmd_op <= 3'd4);

  always_comb begin
    ev_accept    = (state == ST_IDLE) && cmd_valid && op_legal &&
                   (asleep ? (op_in == OP_WAKE) : (op_in != OP_WAKE));
    ev_rdy_seen  = (state == ST_WAIT_RDY) && !rdy_dout;
    ev_start     = ev_rdy_seen && (op_q != OP_SLEEP);
    ev_sleep     = ev_rdy_seen && (op_q == OP_SLEEP);
    ev_phase_end = (state == ST_SHIFT) && tick;
    ev_sample    = ev_phase_end && sclk_q && (pidx < DATA_PULSES);
    ev_last      = ev_phase_end && !sclk_q && (pidx == npulse - PIDX_W'(1));
    ev_fall      = (state == ST_WAIT_FALL) && rdy_q && !rdy_dout;
    ev_expired   = wd_expired &&
                   (((state == ST_WAIT_RDY) && rdy_dout) ||
                    ((state == ST_WAIT_FALL) && !ev_fall));
    timer_load   = ev_start || (ev_phase_end && !ev_last);
    wd_clear     = ev_accept || (ev_last && (op_q == OP_READ_CAL));
  end

  adc2w_phase_timer #(.W(DIV_W)) i_phase (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .half(half_eff), .expire(tick)
  );

  adc2w_capture #(.W(WORD_W)) i_capture (
    .clk(clk), .rst_n(rst_n), .clear(ev_start), .shift_en(ev_sample),
    .bit_in(rdy_dout), .word(cap_word)
  );

  adc2w_wait_timer #(.W(TO_W)) i_wait (
    .clk(clk), .rst_n(rst_n), .clear(wd_clear), .limit(cfg_timeout),
    .expired(wd_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      op_q         <= OP_READ;
      sclk_q       <= 1'b0;
      asleep       <= 1'b0;
      rdy_q        <= 1'b1;
      pidx         <= '0;
      result_q     <= '0;
      result_valid <= 1'b0;
      done         <= 1'b0;
      timeout_err  <= 1'b0;
    end else begin
      rdy_q        <= rdy_dout;
      result_valid <= 1'b0;
      done         <= 1'b0;
      timeout_err  <= 1'b0;
      case (state)
        ST_IDLE: if (ev_accept) begin
          op_q <= op_in;
          if (op_in == OP_WAKE) begin
            asleep <= 1'b0;
            sclk_q <= 1'b0;
            state  <= ST_WAIT_FALL;
          end else begin
            state  <= ST_WAIT_RDY;
          end
        end
        ST_WAIT_RDY: begin
          if (ev_sleep) begin
            sclk_q <= 1'b1;
            asleep <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else if (ev_start) begin
            sclk_q <= 1'b1;
            pidx   <= '0;
            state  <= ST_SHIFT;
          end else if (ev_expired) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        ST_SHIFT: if (ev_phase_end) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
          end else if (ev_last) begin
            result_q     <= cap_word;
            result_valid <= 1'b1;
            if (op_q == OP_READ_CAL) state <= ST_WAIT_FALL;
            else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end else begin
            pidx   <= pidx + PIDX_W'(1);
            sclk_q <= 1'b1;
          end
        end
        ST_WAIT_FALL: begin
          if (ev_fall) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (ev_expired) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk        = sclk_q;
  assign busy        = (state != ST_IDLE);
  assign result      = result_q;
  assign result_sext = sign_extend(result_q);

  // ---------------- assertion support ----------------
  logic             sclk_prev, seen_toggle;
  logic [DIV_W-1:0] run_len;
  logic [PIDX_W:0]  rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev   <= 1'b0;
      seen_toggle <= 1'b0;
      run_len     <= '0;
      rise_cnt    <= '0;
    end else begin
      sclk_prev <= sclk_q;
      if (sclk_q != sclk_prev) begin
        seen_toggle <= 1'b1;
        run_len     <= DIV_W'(1);
      end else if (run_len < DIV_W'(MIN_HALF)) begin
        run_len <= run_len + DIV_W'(1);
      end
      if (ev_accept)                 rise_cnt <= '0;
      else if (sclk_q && !sclk_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_PHASE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_toggle && (sclk_q != sclk_prev)) |-> (run_len >= DIV_W'(MIN_HALF))); // R5
  AST_PULSE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (rise_cnt == {1'b0, npulse})); // R4
  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (sclk_q == asleep)); // R7
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (op_q == $past(op_q))); // R2
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err)); // R10
endmodule

// File: tb/test_adc2w_host_reader.sv
module test_adc2w_host_reader;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned TO_W  = 12;
  localparam int unsigned MINH  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_op = 3'd0;
  logic             busy;
  logic [DIV_W-1:0] cfg_half = 8'd5;
  logic [TO_W-1:0]  cfg_timeout = 12'd1000;
  logic             sclk;
  logic             rdy_dout;
  logic [23:0]      result;
  logic [31:0]      result_sext;
  logic             result_valid, done, timeout_err;

  always #4 clk = ~clk;

  adc2w_host_reader #(.DIV_W(DIV_W), .TO_W(TO_W), .MIN_HALF(MINH)) i_adc2w_host_reader (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy),
    .cfg_half(cfg_half), .cfg_timeout(cfg_timeout), .sclk(sclk), .rdy_dout(rdy_dout),
    .result(result), .result_sext(result_sext), .result_valid(result_valid),
    .done(done), .timeout_err(timeout_err)
  );

  // converter model: mode 0 = line high, 1 = line low, 2 = ready then data
  int          rises = 0;
  int          base = 0;
  int          line_mode = 0;
  logic [23:0] word = '0;

  function automatic logic model_bit(int k, logic [23:0] w);
    if (k <= 0)  return 1'b0;
    if (k <= 24) return w[24-k];
    return 1'b1;
  endfunction

  always @(posedge sclk) rises <= rises + 1;
  assign rdy_dout = (line_mode == 0) ? 1'b1 :
                    (line_mode == 1) ? 1'b0 : model_bit(rises - base, word);

  // phase length monitor
  int run = 0, hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0;
  logic last_sclk = 1'b0;
  always @(negedge clk) begin
    if (sclk != last_sclk) begin
      if (last_sclk) begin
        if (run < hi_min) hi_min = run;
        if (run > hi_max) hi_max = run;
      end else if (busy && rises > 0) begin
        if (run < lo_min) lo_min = run;
        if (run > lo_max) lo_max = run;
      end
      run = 1;
    end else run = run + 1;
    last_sclk = sclk;
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_pulses(int op);
    return (op == 0) ? 24 : (op == 1) ? 25 : (op == 2) ? 26 : 0;
  endfunction

  function automatic logic [31:0] sext_ref(logic [23:0] w);
    return w[23] ? (32'(w) + 32'hFF00_0000) : 32'(w);
  endfunction

  task automatic issue(int op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  logic        got_done, got_err, got_rv;
  logic [23:0] rv_word;
  logic [31:0] rv_sext;
  int          wait_cycles;

  task automatic wait_end(bit stop_on_rv);
    got_done = 0; got_err = 0; got_rv = 0; wait_cycles = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      wait_cycles++;
      if (result_valid) begin got_rv = 1; rv_word = result; rv_sext = result_sext; end
      if (done) got_done = 1;
      if (timeout_err) got_err = 1;
      if (done || timeout_err || (stop_on_rv && result_valid)) break;
    end
  endtask

  task automatic reset_phase_stats();
    hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
  endtask

  task automatic do_read(int op, logic [23:0] w);
    word = w;
    base = rises;
    line_mode = 2;
    issue(op);
    if (op == 2) begin
      wait_end(1);
      chk("R4", "cal read result", rv_word, w);
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!busy || done) begin
          chk("R6", "held busy before line fall", {30'd0, busy, done}, 32'd2);
          break;
        end
      end
      line_mode = 1;
      wait_end(0);
      chk("R6", "done after line fall", {31'd0, got_done}, 32'd1);
    end else begin
      wait_end(0);
      chk("R4", "result word", rv_word, w);
      chk("R4", "done", {31'd0, got_done}, 32'd1);
    end
    chk("R4", "sign extension", rv_sext, sext_ref(w));
    chk("R4", "pulse count", 32'(rises - base), 32'(exp_pulses(op)));
  endtask

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0A2C_5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "sclk", {31'd0, sclk}, 0);
    chk("R1", "busy", {31'd0, busy}, 0);
    chk("R1", "strobes", {29'd0, result_valid, done, timeout_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "result", {8'd0, result}, 0);

    // R4 directed words: plain read, release read
    do_read(0, 24'h800000);
    chk("R4", "line idles at last bit", {31'd0, rdy_dout}, 0);
    do_read(1, 24'h7FFFFF);
    chk("R4", "line released high", {31'd0, rdy_dout}, 1);
    do_read(2, 24'hA5C3_11);

    // R5 clamp and above floor
    cfg_half = 8'd2;
    reset_phase_stats();
    do_read(0, 24'h123456);
    chk("R5", "high phase clamped", 32'(hi_max), 32'(MINH));
    chk("R5", "low phase clamped", 32'(lo_min), 32'(MINH));
    cfg_half = 8'd7;
    reset_phase_stats();
    do_read(1, 24'hFEDCBA);
    chk("R5", "high phase min", 32'(hi_min), 7);
    chk("R5", "low phase max", 32'(lo_max), 7);

    // R3 no pulses while line is high
    cfg_half = 8'd5;
    line_mode = 0;
    base = rises;
    issue(0);
    repeat (40) @(negedge clk);
    chk("R3", "no pulse before ready", 32'(rises - base), 0);
    chk("R3", "busy while waiting", {31'd0, busy}, 1);
    word = 24'h0F0F0F;
    base = rises;
    line_mode = 2;
    wait_end(0);
    chk("R3", "read after late ready", rv_word, 24'h0F0F0F);

    // R2 command during busy ignored
    word = 24'h3C3C3C;
    base = rises;
    line_mode = 2;
    issue(0);
    repeat (20) @(negedge clk);
    issue(2);
    wait_end(0);
    chk("R2", "busy command ignored", 32'(rises - base), 24);
    repeat (10) @(negedge clk);
    chk("R2", "idle after ignored command", {31'd0, busy}, 0);
    issue(6);
    @(negedge clk);
    chk("R2", "illegal code ignored", {31'd0, busy}, 0);

    // R9 timeout
    cfg_timeout = 12'd30;
    line_mode = 0;
    base = rises;
    issue(1);
    wait_end(0);
    chk("R9", "timeout flagged", {30'd0, got_err, got_done}, 32'd2);
    chk("R9", "timeout window", 32'(wait_cycles >= 29 && wait_cycles <= 34), 1);
    chk("R9", "no pulses on timeout", 32'(rises - base), 0);
    chk("R9", "idle after timeout", {31'd0, busy}, 0);
    cfg_timeout = 12'd1000;

    // R8 wake while awake ignored
    issue(4);
    @(negedge clk);
    chk("R8", "wake while awake ignored", {30'd0, busy, sclk}, 0);

    // R7 sleep
    line_mode = 1;
    issue(3);
    wait_end(0);
    chk("R7", "sleep done", {31'd0, got_done}, 1);
    line_mode = 0;
    repeat (50) @(negedge clk);
    chk("R7", "clock parked high", {30'd0, sclk, busy}, 32'd2);
    base = rises;
    issue(0);
    repeat (5) @(negedge clk);
    chk("R7", "read while asleep ignored", {30'd0, sclk, busy}, 32'd2);
    // R8 wake
    issue(4);
    chk("R8", "wake drops clock", {30'd0, sclk, busy}, 32'd1);
    repeat (20) @(negedge clk);
    chk("R8", "waiting for new result", {30'd0, busy, done}, 32'd2);
    line_mode = 1;
    wait_end(0);
    chk("R8", "wake done", {30'd0, got_done, got_err}, 32'd2);
    chk("R8", "no pulses on wake", 32'(rises - base), 0);

    // randomized reads
    for (int it = 0; it < 8; it++) begin
      int op;
      op = int'($urandom % 3);
      cfg_half = 8'(1 + ($urandom % 8));
      reset_phase_stats();
      do_read(op, 24'($urandom));
      chk("R5", "random phase", 32'(hi_max),
          32'((cfg_half < MINH) ? MINH : cfg_half));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule